// File: doc/BRIEF.md
# Radix-4 SRT Fractional Divider

This block is a sequential divider for unsigned fixed-point fractions. It produces two quotient bits per cycle with radix-4 SRT. The divisor must be normalised, meaning its top bit is set, so its value lies in [0.5, 1). The dividend must be smaller than the divisor, which keeps the quotient below one. A one-cycle start pulse loads the operands and a precision select. The block then runs the digit recurrence on its own and raises a one-cycle done pulse once the quotient and remainder are valid.

Each step uses a small selection function to pick a signed quotient digit from −2 to +2. The function looks only at seven truncated bits of the shifted partial remainder and three divisor bits. The partial remainder is kept exactly in two's complement. Two accumulators collect the positive and the negative digit magnitudes separately. After the last step, one full-width subtraction turns them into a binary quotient. A sign test on the final remainder then applies a single correction step, in which the quotient is decremented and the divisor is added back.

Top module: `srt4_divider`

## Requirements
- R1: Every quotient digit lies in {−2, −1, 0, +1, +2}. It is chosen only from the shifted partial remainder truncated to 1/16 of the divisor scale (7-bit signed estimate) and the three divisor bits below the leading one. Every cell of this selection space yields a valid digit.
- R2: During every iteration, the partial remainder w, taken relative to the pre-scaled divisor 4·D, satisfies 3·|w| ≤ 8·D.
- R3: With `precHalf`=0, dividend N and divisor D (D[W−1]=1, N<D) give `quotient` = floor(N·2^W / D) and `remainder` = N·2^W − quotient·D.
- R4: With `precHalf`=1, the result is `quotient` = floor(N·2^(W/2) / D), with the upper W/2 bits zero, and `remainder` = N·2^(W/2) − quotient·D.
- R5: Count the rising edge that samples `start` as edge 1. `done` is then high directly after edge W/2+3 in full precision, or after edge W/4+3 in half precision.
- R6: `done` is high for exactly one cycle. `quotient` and `remainder` hold their values until the next completion. After reset, `done`, `quotient` and `remainder` are zero.
- R7: A `start` that arrives while a division is in progress is ignored. The running division finishes with its own operands and its own timing.
- R8: After the final correction, `remainder` lies in [0, D). This holds at the operand extremes D = 2^(W−1), D = 2^W − 1, N = 0 and N = D − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a division when the block is idle |
| precHalf | input | 1 | 1 selects a W/2-bit quotient, 0 selects a W-bit quotient |
| dividend | input | W | Dividend fraction, must be below the divisor |
| divisor | input | W | Normalised divisor fraction, top bit set |
| quotient | output | W | Binary quotient |
| remainder | output | W | Non-negative remainder |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a step in which the truncated remainder estimate falls in a cell next to a digit boundary, at a divisor index where the overlap between adjacent digits is narrowest. This is also the step where an imprecise digit must be repaired by a later one. The stimulus reaches it by sweeping all eight divisor index values against dividends spread in eighths of the divisor, with random low bits. Random normalised operands come on top of this, in both precisions. Dividends just below the divisor, and divisors at exactly one half and just under one, push the final remainder towards the sign where the closing correction has to act.

// File: rtl/srt4_pkg.sv
package srt4_pkg;
  // Remainder estimate: 7 signed bits, 4 of them fractional (units of 1/16)
  localparam int EST_BITS = 7;
  localparam int EST_FRAC = 4;
  // Divisor index: bits below the leading one (units of 1/16 with the leading one)
  localparam int DIV_IDX_BITS = 3;

  typedef logic signed [2:0] srtDigit_t;

  typedef struct packed {
    logic load;    // capture operands, clear accumulators
    logic step;    // one radix-4 recurrence step
    logic finish;  // resolve quotient and apply the sign correction
  } srtStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } srtState_t;
endpackage

// File: rtl/srt4_select.sv
module srt4_select
  import srt4_pkg::*;
(
  input  logic signed [EST_BITS-1:0]     remEst,
  input  logic        [DIV_IDX_BITS-1:0] divEst,
  output srtDigit_t                      digit
);
  localparam int IDX_SCALE = DIV_IDX_BITS + 1;

  // Digit k is valid when the shifted remainder X lies within
  // [(k-2/3)d, (k+2/3)d]. A cell spans X in [t, t+1) estimate units and d in
  // [i, i+1) index units. Each bound is tested at the worst corner, scaled by 3.
  function automatic srtDigit_t pickDigit(int t, int i);
    int tLo;
    int tHi;
    tLo = 3 * t * (1 << IDX_SCALE);
    tHi = 3 * (t + 1) * (1 << IDX_SCALE);
    if (tLo >= 4 * (i + 1) * (1 << EST_FRAC))
      return 3'sd2;
    if (tLo >= (i + 1) * (1 << EST_FRAC) && tHi <= 5 * i * (1 << EST_FRAC))
      return 3'sd1;
    if (tLo >= -2 * i * (1 << EST_FRAC) && tHi <= 2 * i * (1 << EST_FRAC))
      return 3'sd0;
    if (tLo >= -5 * i * (1 << EST_FRAC) && tHi <= -(i + 1) * (1 << EST_FRAC))
      return -3'sd1;
    return -3'sd2;
  endfunction

  always_comb begin
    digit = pickDigit(int'(remEst), (1 << DIV_IDX_BITS) + int'(divEst));
  end
endmodule

// File: rtl/srt4_datapath.sv
module srt4_datapath
  import srt4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  srtStrobes_t                  strb,
  input  logic [W-1:0]                 dividend,
  input  logic [W-1:0]                 divisor,
  input  srtDigit_t                    digit,
  output logic signed [W+4:0]          partRem,
  output logic signed [EST_BITS-1:0]   remEst,
  output logic [DIV_IDX_BITS-1:0]      divEst,
  output logic [W-1:0]                 quotient,
  output logic [W-1:0]                 remainder
);
  localparam int RW = W + 5;   // sign, guard and pre-scale bits over W
  localparam int QW = W + 2;   // one digit more than W/2 digits

  logic [W-1:0]          dReg;
  logic [QW-1:0]         qPos;
  logic [QW-1:0]         qNeg;
  logic signed [RW-1:0]  shifted;
  logic signed [RW-1:0]  d4;
  logic signed [RW-1:0]  stepRem;
  srtDigit_t             negDig;
  logic [W-1:0]          qBin;
  logic [W-1:0]          fixQ;
  logic [W-1:0]          fixR;

  always_comb begin
    shifted = partRem <<< 2;
    d4      = $signed({3'b000, dReg, 2'b00});
    remEst  = shifted[RW-1 -: EST_BITS];
    divEst  = dReg[W-2 -: DIV_IDX_BITS];
    negDig  = -digit;
    unique case (digit)
      3'sb010: stepRem = shifted - (d4 <<< 1);
      3'sb001: stepRem = shifted - d4;
      3'sb111: stepRem = shifted + d4;
      3'sb110: stepRem = shifted + (d4 <<< 1);
      default: stepRem = shifted;
    endcase
  end

  // Full-width subtraction of the two digit accumulators, then the sign step
  always_comb begin
    qBin = W'(qPos - qNeg);
    if (partRem[RW-1]) begin
      fixQ = qBin - W'(1);
      fixR = partRem[W+1:2] + dReg;
    end else begin
      fixQ = qBin;
      fixR = partRem[W+1:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partRem   <= '0;
      dReg      <= '0;
      qPos      <= '0;
      qNeg      <= '0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (strb.load) begin
        partRem <= $signed({5'b00000, dividend});
        dReg    <= divisor;
        qPos    <= '0;
        qNeg    <= '0;
      end else if (strb.step) begin
        partRem <= stepRem;
        qPos    <= {qPos[QW-3:0], digit[2] ? 2'b00 : digit[1:0]};
        qNeg    <= {qNeg[QW-3:0], digit[2] ? negDig[1:0] : 2'b00};
      end
      if (strb.finish) begin
        quotient  <= fixQ;
        remainder <= fixR;
      end
    end
  end
endmodule

// File: rtl/srt4_control.sv
module srt4_control
  import srt4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        precHalf,
  output srtStrobes_t strb,
  output logic        done
);
  localparam int ITER_FULL = W / 2 + 1;
  localparam int ITER_HALF = W / 4 + 1;
  localparam int CW        = $clog2(ITER_FULL + 1);

  srtState_t     state;
  logic [CW-1:0] iterLeft;

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.step   = (state == ST_RUN);
    strb.finish = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= strb.finish;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_RUN;
          iterLeft <= precHalf ? CW'(ITER_HALF) : CW'(ITER_FULL);
        end
        ST_RUN: begin
          iterLeft <= iterLeft - CW'(1);
          if (iterLeft == CW'(1)) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
  import srt4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         precHalf,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  srtStrobes_t                   strb;
  srtDigit_t                     digit;
  logic signed [W+4:0]           partRem;
  logic signed [EST_BITS-1:0]    remEst;
  logic [DIV_IDX_BITS-1:0]       divEst;

  srt4_control #(.W(W)) uControl (
    .clk(clk), .rstN(rstN), .start(start), .precHalf(precHalf),
    .strb(strb), .done(done)
  );

  srt4_select uSelect (
    .remEst(remEst), .divEst(divEst), .digit(digit)
  );

  srt4_datapath #(.W(W)) uDatapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dividend(dividend), .divisor(divisor), .digit(digit),
    .partRem(partRem), .remEst(remEst), .divEst(divEst),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: rtl/srt4_divider_chk.sv
module srt4_divider_chk
  import srt4_pkg::*;
#(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rstN,
  input srtStrobes_t         strb,
  input srtDigit_t           digit,
  input logic signed [W+4:0] partRem,
  input logic                precHalf,
  input logic [W-1:0]        dividend,
  input logic [W-1:0]        divisor,
  input logic [W-1:0]        quotient,
  input logic [W-1:0]        remainder,
  input logic                done
);
  localparam int PW = 2 * W + 2;

  logic [W-1:0]  nCap;
  logic [W-1:0]  dCap;
  logic          hCap;
  logic [7:0]    sinceLoad;
  logic [W+4:0]  remMag;
  logic [W+7:0]  boundL;
  logic [W+7:0]  boundR;
  logic [PW-1:0] recon;
  logic [PW-1:0] target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nCap      <= '0;
      dCap      <= '0;
      hCap      <= 1'b0;
      sinceLoad <= '0;
    end else begin
      if (strb.load) begin
        nCap      <= dividend;
        dCap      <= divisor;
        hCap      <= precHalf;
        sinceLoad <= 8'd1;
      end else if (sinceLoad != 8'hFF) begin
        sinceLoad <= sinceLoad + 8'd1;
      end
    end
  end

  always_comb begin
    remMag = partRem[W+4] ? (W+5)'(-partRem) : (W+5)'(partRem);
    boundL = (W+8)'(remMag) * (W+8)'(3);
    boundR = (W+8)'(dCap) << 3;
    recon  = PW'(quotient) * PW'(dCap) + PW'(remainder);
    target = hCap ? (PW'(nCap) << (W / 2)) : (PW'(nCap) << W);
  end

  p_digit_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (int'(digit) >= -2 && int'(digit) <= 2));

  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (boundL <= boundR));

  p_full_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hCap) |-> (recon == target));

  p_half_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && hCap) |-> (recon == target && quotient[W-1:W/2] == '0));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(sinceLoad) == (hCap ? W / 4 + 3 : W / 2 + 3)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> ($stable(quotient) && $stable(remainder)));

  p_rem_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remainder < dCap));
endmodule

bind srt4_divider srt4_divider_chk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .digit(digit), .partRem(partRem),
  .precHalf(precHalf), .dividend(dividend), .divisor(divisor),
  .quotient(quotient), .remainder(remainder), .done(done)
);

// File: tb/test_srt4_divider.sv
module test_srt4_divider;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         precHalf = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  srt4_divider #(.W(W)) i_srt4_divider (
    .clk(clk), .rstN(rstN), .start(start), .precHalf(precHalf),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bit-serial restoring long division, one quotient bit per pass
  task automatic refDiv(input longint n, input longint d, input bit half,
                        output longint q, output longint r);
    int bits;
    bits = half ? W / 2 : W;
    q = 0;
    r = n;
    for (int b = 0; b < bits; b++) begin
      r = r * 2;
      q = q * 2;
      if (r >= d) begin
        r = r - d;
        q = q + 1;
      end
    end
  endtask

  task automatic runDiv(input logic [W-1:0] n, input logic [W-1:0] d, input bit half,
                        output int lat);
    bit got;
    @(negedge clk);
    dividend = n;
    divisor  = d;
    precHalf = half;
    start    = 1'b1;
    got = 0;
    lat = 0;
    for (int c = 1; c <= 40 && !got; c++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        got = 1;
        lat = c;
      end
    end
  endtask

  task automatic checkDiv(input logic [W-1:0] n, input logic [W-1:0] d, input bit half,
                          input string req);
    int lat;
    longint q;
    longint r;
    runDiv(n, d, half, lat);
    refDiv(longint'(n), longint'(d), half, q, r);
    chk(longint'(quotient) == q, {req, " quotient"}, longint'(quotient), q);
    chk(longint'(remainder) == r, {req, " remainder"}, longint'(remainder), r);
    chk(lat == (half ? W / 4 + 3 : W / 2 + 3), "R5 latency", lat, half ? W / 4 + 3 : W / 2 + 3);
    chk(remainder < d, "R8 remainder below divisor", longint'(remainder), longint'(d));
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] n;
    logic [W-1:0] holdQ;
    logic [W-1:0] holdR;
    longint q;
    longint r;
    int lat;
    bit got;

    void'($urandom(32'h5EED_2A17));

    // R6: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R6 reset done", done, 0);
    chk(quotient == '0, "R6 reset quotient", longint'(quotient), 0);
    chk(remainder == '0, "R6 reset remainder", longint'(remainder), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: operand extremes in both precisions
    for (int h = 0; h < 2; h++) begin
      checkDiv(16'h0000, 16'h8000, bit'(h), "R8 N=0 D=half");
      checkDiv(16'h7FFF, 16'h8000, bit'(h), "R8 N=D-1 D=half");
      checkDiv(16'hFFFE, 16'hFFFF, bit'(h), "R8 N=D-1 D=max");
      checkDiv(16'h0001, 16'hFFFF, bit'(h), "R8 N=1 D=max");
      checkDiv(16'h8000, 16'h8001, bit'(h), "R8 N=half D=half+1");
    end

    // R1 R2: every divisor index against dividends in eighths of the divisor
    for (int idx = 0; idx < 8; idx++) begin
      for (int k = 0; k < 8; k++) begin
        d = 16'h8000 | 16'(idx << 12) | 16'($urandom_range(0, 16'h0FFF));
        n = 16'((longint'(d) * k) / 8) + 16'($urandom_range(0, 63));
        if (n >= d) n = d - 16'd1;
        checkDiv(n, d, bit'(k % 2), "R1 R2 table sweep");
      end
    end

    // R3: random full precision
    for (int i = 0; i < 250; i++) begin
      d = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
      n = 16'($urandom_range(0, 32'(d) - 1));
      checkDiv(n, d, 1'b0, "R3 full precision");
    end

    // R4: random half precision
    for (int i = 0; i < 150; i++) begin
      d = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
      n = 16'($urandom_range(0, 32'(d) - 1));
      checkDiv(n, d, 1'b1, "R4 half precision");
      chk(quotient[W-1:W/2] == '0, "R4 upper quotient zero", longint'(quotient[W-1:W/2]), 0);
    end

    // R6: results hold while inputs change without a start
    checkDiv(16'h5A5A, 16'hC3C3, 1'b0, "R6 setup");
    holdQ = quotient;
    holdR = remainder;
    dividend = 16'h1234;
    divisor  = 16'h9999;
    precHalf = 1'b1;
    repeat (6) @(negedge clk);
    chk(quotient == holdQ, "R6 quotient held", longint'(quotient), longint'(holdQ));
    chk(remainder == holdR, "R6 remainder held", longint'(remainder), longint'(holdR));

    // R7: second start during a running division is ignored
    @(negedge clk);
    dividend = 16'h6F00;
    divisor  = 16'hA123;
    precHalf = 1'b0;
    start    = 1'b1;
    got = 0;
    lat = 0;
    for (int c = 1; c <= 40 && !got; c++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (c == 3) begin
        dividend = 16'h0101;
        divisor  = 16'hF000;
        precHalf = 1'b1;
        start    = 1'b1;
      end
      if (done) begin
        got = 1;
        lat = c;
      end
    end
    start = 1'b0;
    refDiv(longint'(16'h6F00), longint'(16'hA123), 1'b0, q, r);
    chk(longint'(quotient) == q, "R7 busy start quotient", longint'(quotient), q);
    chk(longint'(remainder) == r, "R7 busy start remainder", longint'(remainder), r);
    chk(lat == W / 2 + 3, "R7 busy start latency", lat, W / 2 + 3);
    repeat (W) @(negedge clk);
    chk(done == 1'b0, "R7 no second completion", done, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule